// File: doc/BRIEF.md
# Serial Eight-Point DCT Core (Multiplier-Free)

This block takes a stream of signed 12-bit samples, one per clock when `in_valid` is high, and cuts it into groups of eight. For each group it computes the one-dimensional eight-point type-II discrete cosine transform. It uses the Loeffler factorization: a tree of butterflies with three plane rotations and two scalings by the square root of two. Every one of those constant products is built as a fixed sum of shifted copies of its operand, so the datapath contains no multiplier.

The coefficients leave on a single signed 12-bit port, one per clock, lowest index first. A group is gathered in a fill buffer while the previous group's coefficients are still being emitted. A continuous input stream therefore yields a continuous output stream. The core is meant to serve as the row or column pass of a two-dimensional transform built around it. Scaling is fixed: every output is the Loeffler flow-graph result divided by eight, rounded half-up and clamped to 12 bits.

Top module: `dct8_serial`

## Requirements
- R1: After reset is released, `out_valid` stays low until a full group of eight samples has been accepted.
- R2: A cycle with `in_valid` low is ignored whatever `in_sample` carries. A group is made of the next eight accepted samples in arrival order, x0 first.
- R3: For k = 1..7, `out_coef` (two's complement) is within 1 LSB of round(S_k / (4·√2)), where S_k = Σ x_n·cos((2n+1)·k·π/16).
- R4: Each group yields exactly eight consecutive cycles with `out_valid` high, carrying X0, X1, ..., X7 in that order. `out_valid` is low at all other times.
- R5: If the eighth sample of a group is accepted at rising edge n, coefficient X_k is presented between edges n+1+k and n+2+k.
- R6: When groups arrive back to back (eight accepted samples in eight cycles, repeatedly), the coefficient bursts follow each other with no idle cycle.
- R7: Results are clamped to the range −2048..+2047. An input with x at +2047 where the sign pattern (+,−,−,+,+,−,−,+) is + and at −2048 where it is − gives X4 = +2047.
- R8: X0 = floor((Σx_n + 4) / 8) and X4 = floor((x0−x1−x2+x3+x4−x5−x6+x7 + 4) / 8), exactly. This is round-half-up of the sum divided by eight, so +0.5 becomes 1 and −0.5 becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | High when `in_sample` holds a sample to accept |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | High while `out_coef` holds a coefficient |
| out_coef | output | 12 | Signed coefficient, X0 to X7 in order |

## Verification
The group is latched at the edge that accepts its eighth sample. The transform is registered one edge later, which makes X_k due k+1 edges after that acceptance edge. The driver stamps each expected coefficient with the cycle counter value at which it must appear. The monitor samples on the falling clock and compares both the cycle and the value of every coefficient against the head of the queue, so a late, early or missing burst is caught as well as a wrong value. Any `out_valid` with an empty queue, and any entry left over at the end, count as failures.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  // Number of points per transform
  localparam int DCT_N = 8;
  // Fraction bits of the rotation constants
  localparam int CONST_FRAC = 12;

  // Rotation constants in units of 2^-CONST_FRAC
  localparam int unsigned K_C1  = 4017;  // cos(pi/16)
  localparam int unsigned K_S1  = 799;   // sin(pi/16)
  localparam int unsigned K_C3  = 3406;  // cos(3pi/16)
  localparam int unsigned K_S3  = 2276;  // sin(3pi/16)
  localparam int unsigned K_R2C = 5352;  // sqrt2*cos(pi/8)
  localparam int unsigned K_R2S = 2217;  // sqrt2*sin(pi/8)
  localparam int unsigned K_RT2 = 5793;  // sqrt2

  // Constant used by rotation product slot idx
  function automatic int unsigned rot_const(input int idx);
    case (idx)
      0, 3:    return K_C3;
      1, 2:    return K_S3;
      4, 7:    return K_C1;
      5, 6:    return K_S1;
      8, 11:   return K_R2C;
      default: return K_R2S;
    endcase
  endfunction
endpackage

// File: rtl/dct8_const_mul.sv
// Constant product built only from shifted copies of the operand.
// The result is rounded back to the operand's scale.
module dct8_const_mul #(
  parameter int          IW   = 19,
  parameter int          CB   = 12,
  parameter int unsigned CVAL = 0
) (
  input  logic signed [IW-1:0] a_i,
  output logic signed [IW-1:0] p_o
);
  localparam int PW = IW + CB + 2;
  localparam int NB = CB + 1;
  localparam logic [31:0] CV = 32'(CVAL);
  localparam logic signed [PW-1:0] RHALF = PW'(1) <<< (CB - 1);

  logic signed [PW-1:0] ext;
  logic signed [PW-1:0] acc [NB+1];

  assign ext    = PW'(a_i);
  assign acc[0] = '0;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    if (CV[i]) begin : g_add
      assign acc[i+1] = acc[i] + (ext <<< i);
    end else begin : g_pass
      assign acc[i+1] = acc[i];
    end
  end

  assign p_o = IW'((acc[NB] + RHALF) >>> CB);
endmodule

// File: rtl/dct8_collector.sv
// Gathers eight accepted samples and hands the full group over in one edge.
module dct8_collector #(
  parameter int W = 12,
  parameter int N = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic signed [W-1:0] in_sample_i,
  output logic signed [W-1:0] grp_o [N],
  output logic                go_o
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0]       cnt_q, cnt_d;
  logic                go_q;
  logic                fill_en, grp_en;
  logic signed [W-1:0] fill_q [N-1];
  logic signed [W-1:0] grp_q  [N];

  always_comb begin
    fill_en = in_valid_i && (cnt_q != LAST);
    grp_en  = in_valid_i && (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (in_valid_i) cnt_d = grp_en ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      go_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      go_q  <= grp_en;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en) fill_q[cnt_q] <= in_sample_i;
  end

  always_ff @(posedge clk_i) begin
    if (grp_en) begin
      for (int n = 0; n < N - 1; n++) grp_q[n] <= fill_q[n];
      grp_q[N-1] <= in_sample_i;
    end
  end

  assign grp_o = grp_q;
  assign go_o  = go_q;

  // R2
  idle_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(cnt_q) && !go_q));
endmodule

// File: rtl/dct8_loeffler.sv
// Loeffler flow graph with shift-add constants.
// Each output is the flow result divided by eight, rounded half-up and clamped.
module dct8_loeffler #(
  parameter int W = 12,
  parameter int F = 3
) (
  input  logic signed [W-1:0] x_i [dct8_pkg::DCT_N],
  output logic signed [W-1:0] y_o [dct8_pkg::DCT_N]
);
  localparam int N  = dct8_pkg::DCT_N;
  localparam int IW = W + 4 + F;
  localparam int SH = F + 3;
  localparam logic signed [IW-1:0] HALF = IW'(1) <<< (SH - 1);
  localparam logic signed [IW-1:0] QMAX = IW'((1 <<< (W - 1)) - 1);
  localparam logic signed [IW-1:0] QMIN = -QMAX - IW'(1);

  logic signed [IW-1:0] a  [N];
  logic signed [IW-1:0] b  [4];
  logic signed [IW-1:0] mi [12];
  logic signed [IW-1:0] mo [12];
  logic signed [IW-1:0] c4, c5, c6, c7, d4, d5, d6, d7, r5, r6;
  logic signed [IW-1:0] lr [N];
  logic signed [IW-1:0] q  [N];

  // input butterfly, even split and rotation operands
  always_comb begin
    for (int n = 0; n < N / 2; n++) begin
      a[n]       = (IW'(x_i[n]) + IW'(x_i[N-1-n])) <<< F;
      a[N-1-n]   = (IW'(x_i[n]) - IW'(x_i[N-1-n])) <<< F;
    end
    b[0] = a[0] + a[3];
    b[1] = a[1] + a[2];
    b[2] = a[1] - a[2];
    b[3] = a[0] - a[3];
    mi[0] = a[4];  mi[1] = a[7];  mi[2]  = a[4]; mi[3]  = a[7];
    mi[4] = a[5];  mi[5] = a[6];  mi[6]  = a[5]; mi[7]  = a[6];
    mi[8] = b[3];  mi[9] = b[2];  mi[10] = b[3]; mi[11] = b[2];
  end

  for (genvar g = 0; g < 12; g++) begin : g_rot
    dct8_const_mul #(
      .IW  (IW),
      .CB  (dct8_pkg::CONST_FRAC),
      .CVAL(dct8_pkg::rot_const(g))
    ) u_mul (
      .a_i(mi[g]),
      .p_o(mo[g])
    );
  end

  // odd-part rotations and their cross butterfly
  always_comb begin
    c4 = mo[0] + mo[1];
    c7 = mo[3] - mo[2];
    c5 = mo[4] + mo[5];
    c6 = mo[7] - mo[6];
    d4 = c4 + c6;
    d6 = c4 - c6;
    d7 = c7 + c5;
    d5 = c7 - c5;
  end

  dct8_const_mul #(.IW(IW), .CB(dct8_pkg::CONST_FRAC), .CVAL(dct8_pkg::K_RT2))
    u_rt2_a (.a_i(d5), .p_o(r5));
  dct8_const_mul #(.IW(IW), .CB(dct8_pkg::CONST_FRAC), .CVAL(dct8_pkg::K_RT2))
    u_rt2_b (.a_i(d6), .p_o(r6));

  // outputs, scaling, rounding and clamping
  always_comb begin
    lr[0] = b[0] + b[1];
    lr[4] = b[0] - b[1];
    lr[2] = mo[8] + mo[9];
    lr[6] = mo[10] - mo[11];
    lr[1] = d7 + d4;
    lr[7] = d7 - d4;
    lr[3] = r5;
    lr[5] = r6;
    for (int k = 0; k < N; k++) begin
      q[k] = (lr[k] + HALF) >>> SH;
      if (q[k] > QMAX)      y_o[k] = QMAX[W-1:0];
      else if (q[k] < QMIN) y_o[k] = QMIN[W-1:0];
      else                  y_o[k] = q[k][W-1:0];
    end
  end
endmodule

// File: rtl/dct8_serializer.sv
// Holds one group of coefficients and emits them one per clock.
module dct8_serializer #(
  parameter int W = 12,
  parameter int N = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic signed [W-1:0] coef_i [N],
  output logic                out_valid_o,
  output logic signed [W-1:0] out_coef_o
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0]       idx_q, idx_d;
  logic                busy_q, busy_d;
  logic signed [W-1:0] coef_q [N];

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    if (go_i) begin
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (go_i) coef_q <= coef_i;
  end

  assign out_valid_o = busy_q;
  assign out_coef_o  = coef_q[idx_q];

  // R4
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST && !go_i) |=> (busy_q && idx_q == CW'($past(idx_q) + 1'b1)));
  // R4
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST && !go_i) |=> !busy_q);
  // R5
  burst_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (busy_q && idx_q == '0));
  // R6
  seamless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && busy_q) |-> (idx_q == LAST));
endmodule

// File: rtl/dct8_serial.sv
module dct8_serial #(
  parameter int W = 12,
  parameter int F = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic         out_valid,
  output logic [W-1:0] out_coef
);
  localparam int N = dct8_pkg::DCT_N;

  logic [1:0]          rsync_q;
  logic                rst_int;
  logic signed [W-1:0] grp  [N];
  logic signed [W-1:0] coef [N];
  logic                go;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  dct8_collector #(.W(W), .N(N)) u_collect (
    .clk_i      (clk),
    .rst_ni     (rst_int),
    .in_valid_i (in_valid),
    .in_sample_i(in_sample),
    .grp_o      (grp),
    .go_o       (go)
  );

  dct8_loeffler #(.W(W), .F(F)) u_xform (
    .x_i(grp),
    .y_o(coef)
  );

  dct8_serializer #(.W(W), .N(N)) u_emit (
    .clk_i      (clk),
    .rst_ni     (rst_int),
    .go_i       (go),
    .coef_i     (coef),
    .out_valid_o(out_valid),
    .out_coef_o (out_coef)
  );
endmodule

// File: tb/dct8_serial_tb.sv
module dct8_serial_tb;
  typedef struct {
    int val;
    int tol;
    int cyc;
    int k;
    int vtag;
    int ttag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_sample;
  logic        out_valid;
  logic [11:0] out_coef;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  int    grp [8];
  item_t exp_q [$];
  item_t it;
  int    got;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dct8_serial u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_coef (out_coef)
  );

  function automatic int clamp12(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int rnd12();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr[11:0]) - 2048;
  endfunction

  // Expected coefficients of grp, due from cycle c0 on.
  // R8 exact for X0/X4, R3 within 1 LSB for the rest.
  task automatic push_expect(input int c0, input int vall, input int vtag4, input int ttag);
    int s0, s4;
    real v;
    item_t e;
    s0 = 0;
    s4 = 0;
    for (int n = 0; n < 8; n++) begin
      s0 += grp[n];
      s4 += (n == 0 || n == 3 || n == 4 || n == 7) ? grp[n] : -grp[n];
    end
    for (int k = 0; k < 8; k++) begin
      e.k = k;
      e.cyc = c0 + k;
      e.ttag = ttag;
      if (k == 0) begin
        e.val = clamp12((s0 + 4) >>> 3); e.tol = 0; e.vtag = 8;
      end else if (k == 4) begin
        e.val = clamp12((s4 + 4) >>> 3); e.tol = 0; e.vtag = (vtag4 != 0) ? vtag4 : 8;
      end else begin
        v = 0.0;
        for (int n = 0; n < 8; n++)
          v += real'(grp[n]) * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
        v = v / (4.0 * $sqrt(2.0));
        e.val = clamp12($rtoi($floor(v + 0.5)));
        e.tol = 1;
        e.vtag = 3;
      end
      if (vall != 0) e.vtag = vall;
      exp_q.push_back(e);
    end
  endtask

  // Drives grp; gap idle cycles (with junk data) before every sample but the first.
  task automatic drive_group(input int gap, input int vall, input int vtag4, input int ttag);
    for (int n = 0; n < 8; n++) begin
      if (gap > 0 && n > 0) begin
        repeat (gap) begin
          in_valid  = 1'b0;
          in_sample = 12'(n * 613 + 1365);
          @(negedge clk);
        end
      end
      in_valid  = 1'b1;
      in_sample = 12'(grp[n]);
      if (n == 7) push_expect(cyc + 2, vall, vtag4, ttag);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_const(input int v);
    for (int n = 0; n < 8; n++) grp[n] = v;
  endtask

  task automatic fill_rand();
    for (int n = 0; n < 8; n++) grp[n] = rnd12();
  endtask

  // scoreboard monitor: R4 order/count, R5/R6 cycle, value tags as stored
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R4: out_valid high with no coefficient due, actual 1 expected 0");
      end else begin
        it = exp_q.pop_front();
        checks++;
        if (cyc != it.cyc) begin
          errors++;
          $display("FAIL R%0d: X%0d at cycle %0d, expected cycle %0d", it.ttag, it.k, cyc, it.cyc);
        end
        got = int'($signed(out_coef));
        checks++;
        if (got > it.val + it.tol || got < it.val - it.tol) begin
          errors++;
          $display("FAIL R%0d: X%0d actual %0d expected %0d (tol %0d)", it.vtag, it.k, got, it.val, it.tol);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R1: quiet after reset with no samples
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
      end
    end
    // R1: seven samples are not a group
    for (int n = 0; n < 8; n++) grp[n] = n * 100 - 350;
    for (int n = 0; n < 7; n++) begin
      in_valid = 1'b1;
      in_sample = 12'(grp[n]);
      @(negedge clk);
    end
    idle(6);
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: out_valid with 7 samples actual %b expected 0", out_valid);
    end
    // complete that group with its eighth sample (R2: idle cycles did not split it)
    in_valid = 1'b1;
    in_sample = 12'(grp[7]);
    push_expect(cyc + 2, 2, 0, 5);
    @(negedge clk);
    idle(12);
    // R3/R8: ramp and constant
    for (int n = 0; n < 8; n++) grp[n] = 350 - n * 90;
    drive_group(0, 0, 0, 5); idle(10);
    fill_const(100);
    drive_group(0, 0, 0, 5); idle(10);
    // R8: half-way rounding, +0.5 -> 1 and -0.5 -> 0
    fill_const(0); grp[0] = 4;
    drive_group(0, 8, 0, 5); idle(10);
    fill_const(0); grp[0] = -4;
    drive_group(0, 8, 0, 5); idle(10);
    // R7: alternating full scale saturates X4 at +2047
    for (int n = 0; n < 8; n++)
      grp[n] = (n == 0 || n == 3 || n == 4 || n == 7) ? 2047 : -2048;
    drive_group(0, 0, 7, 5); idle(10);
    fill_const(-2048);
    drive_group(0, 7, 0, 5); idle(10);
    fill_const(2047);
    drive_group(0, 7, 0, 5); idle(10);
    // R2: gaps with junk on the data lines
    fill_rand();
    drive_group(2, 2, 0, 5); idle(10);
    fill_rand();
    drive_group(1, 2, 0, 5); idle(10);
    // R6: back-to-back groups
    for (int g = 0; g < 16; g++) begin
      fill_rand();
      drive_group(0, 0, 0, 6);
    end
    idle(20);
    // R4: every due coefficient arrived
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: pending coefficients actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule